// File: doc/BRIEF.md
# Ripple-Chained Bit-Slice Four-Function ALU

This block is a combinational arithmetic and logic unit made by chaining identical one-bit slices. A single two-bit operation code is shared by every slice. It selects one of four functions of the operand words: bitwise AND, bitwise OR, the bitwise complement of operand B, or the binary sum of A, B and a carry input. In add mode each slice passes its carry output to the carry input of the slice above it. Bit 0 takes the external carry input, and the carry output of the most significant slice is the external carry output.

Inside each slice, a decoder turns the operation code into four enables, and exactly one of them is high. Every candidate result is ANDed with its own enable, and the gated results are merged by an OR, so no multiplexer is used. The full adder is built only from two-input AND and OR gates and inverters. It first forms a half sum of A and B, then combines that half sum with the carry input. When the operation is not add, the slice forces its carry output to 0, so the carry input has no effect on the result.

The block has no clock and no state. Its width is set by the parameter `WIDTH`, which defaults to 8.

Top module: `alu_ripple`

## Requirements
- R1: With `op_code` = 2'b00, `y_out` equals `a_in & b_in` bit by bit.
- R2: With `op_code` = 2'b01, `y_out` equals `a_in | b_in` bit by bit.
- R3: With `op_code` = 2'b10, `y_out` equals `~b_in`, whatever the value of `a_in`.
- R4: With `op_code` = 2'b11, `y_out` equals the low `WIDTH` bits of `a_in + b_in + c_in`.
- R5: For op codes 2'b00, 2'b01 and 2'b10, the value of `c_in` has no effect on `y_out`.
- R6: For op codes 2'b00, 2'b01 and 2'b10, `c_out` is 0.
- R7: With `op_code` = 2'b11, `c_out` is bit `WIDTH` of `a_in + b_in + c_in`. At slice level, this is 1 when at least two of A, B and the carry input are 1.
- R8: In every slice, exactly one of the four function enables is high for any op code.
- R9: In add mode a carry ripples through all slices. With `a_in` all ones, `b_in` = 0 and `c_in` = 1, the result is `y_out` = 0 and `c_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 2 | Function select: 00 AND, 01 OR, 10 invert B, 11 add |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| c_in | input | 1 | Carry into bit 0; used only in add mode |
| y_out | output | WIDTH | Result word |
| c_out | output | 1 | Carry out of the top slice; 0 outside add mode |

## Verification
The case that is hardest to reach from the ports is a carry that enters at bit 0 and has to travel through every slice before it appears at `c_out`. A single wrong gate in any one slice's propagate path would show only for that pattern. The bench reaches it in two ways. It sweeps every combination of operation code, both operands and carry input at a width of four bits, which covers every propagate chain length. It also applies a dedicated all-ones-plus-carry vector. A second hard case is proving that the carry input is ignored outside add mode. For this, the bench applies each logic operand pair twice, with the carry input flipped, and requires the same result word and a zero carry out both times.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_NOTB = 2'b10,
        OP_ADD  = 2'b11
    } alu_op_e;

    localparam int unsigned NUM_FUNCS = 4;

endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
    import alu_pkg::*;
(
    input  logic [1:0]           code,
    output logic [NUM_FUNCS-1:0] en
);

    logic c0_n;
    logic c1_n;

    assign c0_n = ~code[0];
    assign c1_n = ~code[1];

    always_comb begin
        en[OP_AND]  = c1_n    & c0_n;
        en[OP_OR]   = c1_n    & code[0];
        en[OP_NOTB] = code[1] & c0_n;
        en[OP_ADD]  = code[1] & code[0];
    end

endmodule

// File: rtl/alu_gate_adder.sv
module alu_gate_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic sum,
    output logic co
);

    logic ab_and;
    logic ab_or;
    logic ab_and_n;
    logic half;
    logic hc_and;
    logic hc_or;
    logic hc_and_n;

    // half sum: (a OR b) AND NOT (a AND b)
    assign ab_and   = a & b;
    assign ab_or    = a | b;
    assign ab_and_n = ~ab_and;
    assign half     = ab_or & ab_and_n;

    // final sum: half sum combined with carry input the same way
    assign hc_and   = half & ci;
    assign hc_or    = half | ci;
    assign hc_and_n = ~hc_and;
    assign sum      = hc_or & hc_and_n;

    // carry: both operands set, or half sum and carry set
    assign co       = ab_and | hc_and;

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
(
    input  logic                 a,
    input  logic                 b,
    input  logic                 add_sum,
    input  logic [NUM_FUNCS-1:0] en,
    output logic                 y
);

    logic [NUM_FUNCS-1:0] cand;
    logic [NUM_FUNCS-1:0] gated;

    always_comb begin
        cand[OP_AND]  = a & b;
        cand[OP_OR]   = a | b;
        cand[OP_NOTB] = ~b;
        cand[OP_ADD]  = add_sum;
    end

    for (genvar k = 0; k < NUM_FUNCS; k++) begin : g_gate
        assign gated[k] = cand[k] & en[k];
    end

    assign y = |gated;

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic [1:0] code,
    input  logic       a,
    input  logic       b,
    input  logic       ci,
    output logic       y,
    output logic       co
);

    logic [NUM_FUNCS-1:0] en;
    logic                 fa_sum;
    logic                 fa_co;

    alu_decoder u_dec (
        .code (code),
        .en   (en)
    );

    alu_gate_adder u_fa (
        .a   (a),
        .b   (b),
        .ci  (ci),
        .sum (fa_sum),
        .co  (fa_co)
    );

    alu_logic_unit u_lu (
        .a       (a),
        .b       (b),
        .add_sum (fa_sum),
        .en      (en),
        .y       (y)
    );

    assign co = fa_co & en[OP_ADD];

    always_comb begin
        if (!$isunknown({code, a, b, ci})) begin
            // R8
            en_onehot_chk: assert ($onehot(en))
                else $error("slice enables not one-hot: %b", en);
            // R6
            co_idle_chk: assert (code == OP_ADD || co == 1'b0)
                else $error("slice carry out set outside add");
            // R7
            fa_match_chk: assert (code != OP_ADD ||
                                  {co, y} == (2'(a) + 2'(b) + 2'(ci)))
                else $error("slice add mismatch");
            // R3
            notb_chk: assert (code != OP_NOTB || y == ~b)
                else $error("slice invert-B mismatch");
        end
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] y_out,
    output logic             c_out
);

    localparam int unsigned CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] carry;

    assign carry[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .code (op_code),
            .a    (a_in[i]),
            .b    (b_in[i]),
            .ci   (carry[i]),
            .y    (y_out[i]),
            .co   (carry[i+1])
        );
    end

    assign c_out = carry[WIDTH];

    always_comb begin
        if (!$isunknown({op_code, a_in, b_in, c_in})) begin
            // R4
            word_sum_chk: assert (op_code != OP_ADD ||
                {c_out, y_out} == ((CHAIN)'(a_in) + (CHAIN)'(b_in) + (CHAIN)'(c_in)))
                else $error("word sum mismatch");
            // R6
            word_co_idle_chk: assert (op_code == OP_ADD || c_out == 1'b0)
                else $error("word carry out set outside add");
            // R1
            word_and_chk: assert (op_code != OP_AND || y_out == (a_in & b_in))
                else $error("word AND mismatch");
            // R2
            word_or_chk: assert (op_code != OP_OR || y_out == (a_in | b_in))
                else $error("word OR mismatch");
        end
    end

endmodule

// File: tb/alu_ripple_tb.sv
module alu_ripple_tb;

    localparam int W = 4;
    localparam int MAXV = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_code;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic         c_in;
    logic [W-1:0] y_out;
    logic         c_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    alu_ripple #(.WIDTH(W)) u_dut (
        .op_code (op_code),
        .a_in    (a_in),
        .b_in    (b_in),
        .c_in    (c_in),
        .y_out   (y_out),
        .c_out   (c_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic apply(input logic [1:0] op, input int a, input int b, input int ci);
        @(negedge clk);
        op_code = op;
        a_in    = W'(a);
        b_in    = W'(b);
        c_in    = ci[0];
        @(posedge clk);
        #1;
    endtask

    task automatic expect_word(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: op=%b a=%0h b=%0h ci=%0b actual %0h expected %0h",
                     req, op_code, a_in, b_in, c_in, act, exp);
        end
    endtask

    task automatic test_idle_zero();
        apply(2'b00, 0, 0, 0);
        expect_word("R1", {c_out, y_out}, '0);
    endtask

    task automatic test_and();
        for (int a = 0; a < MAXV; a++)
            for (int b = 0; b < MAXV; b++) begin
                apply(2'b00, a, b, 0);
                expect_word("R1", {1'b0, y_out}, {1'b0, W'(a & b)});
            end
    endtask

    task automatic test_or();
        for (int a = 0; a < MAXV; a++)
            for (int b = 0; b < MAXV; b++) begin
                apply(2'b01, a, b, 0);
                expect_word("R2", {1'b0, y_out}, {1'b0, W'(a | b)});
            end
    endtask

    task automatic test_notb();
        for (int a = 0; a < MAXV; a++)
            for (int b = 0; b < MAXV; b++) begin
                apply(2'b10, a, b, 0);
                expect_word("R3", {1'b0, y_out}, {1'b0, ~W'(b)});
            end
    endtask

    task automatic test_add();
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < MAXV; a++)
                for (int b = 0; b < MAXV; b++) begin
                    apply(2'b11, a, b, ci);
                    expect_word("R4", {1'b0, y_out}, {1'b0, W'(a + b + ci)});
                    expect_word("R7", {W'(0), c_out}, {W'(0), 1'((a + b + ci) >> W)});
                end
    endtask

    task automatic test_cin_ignored();
        logic [W-1:0] y0;
        for (int op = 0; op < 3; op++)
            for (int a = 0; a < MAXV; a++)
                for (int b = 0; b < MAXV; b++) begin
                    apply(2'(op), a, b, 0);
                    y0 = y_out;
                    expect_word("R6", {W'(0), c_out}, '0);
                    apply(2'(op), a, b, 1);
                    expect_word("R5", {1'b0, y_out}, {1'b0, y0});
                    expect_word("R6", {W'(0), c_out}, '0);
                end
    endtask

    task automatic test_full_ripple();
        apply(2'b11, MAXV - 1, 0, 1);
        expect_word("R9", {c_out, y_out}, {1'b1, W'(0)});
        apply(2'b11, MAXV - 1, MAXV - 1, 1);
        expect_word("R9", {c_out, y_out}, {1'b1, W'(MAXV - 1)});
        // R8: each code yields a single function, so AND and OR of the same pair differ
        apply(2'b00, 5, 3, 0);
        expect_word("R8", {c_out, y_out}, {1'b0, W'(1)});
        apply(2'b01, 5, 3, 0);
        expect_word("R8", {c_out, y_out}, {1'b0, W'(7)});
    endtask

    initial begin
        op_code = 2'b00;
        a_in    = '0;
        b_in    = '0;
        c_in    = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_idle_zero();
        test_and();
        test_or();
        test_notb();
        test_add();
        test_cin_ignored();
        test_full_ripple();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule